// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Error FIFO

This block receives one asynchronous serial channel. It samples the line on a 16x bit-rate enable, turns each frame into a character of 5 to 8 bits with optional parity, and stores the character in a small receive queue. Each queue entry also holds that character's break, framing and parity flags, so the host sees the error state of the character it is about to read.

The host sets the character format and error handling through static mode inputs. It removes characters with a one-cycle pop strobe and reads the head of the queue and an 8-bit status word from the outputs. A reset-error command clears the error state, and a receiver reset empties the whole receive path. In character error mode the flags follow each character. In block error mode they are ORed together across characters until the host clears them.

Top module: `uart_rx_errfifo`

## Requirements
- R1: The deserializer advances only on cycles with `rx_tick16` high. A falling edge is accepted as a start bit only if the line is still low 8 ticks later; a low pulse shorter than that produces no character. Data bits arrive LSB first and are sampled at the centre of each bit.
- R2: `mode_bits` sets the character length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 bits. Data bits above the character length read as 0 in `rx_data`.
- R3: When `mode_par` = 00, a parity bit follows the data, and `mode_odd` (0 even, 1 odd) sets the expected total parity. A mismatch sets the parity flag `rx_status[5]`. When `mode_par` = 10, no parity bit is expected and the flag stays 0.
- R4: When `mode_par` = 01 (forced), the parity bit must equal `mode_odd`. When `mode_par` = 11 (multidrop), `rx_status[5]` carries the received ninth bit, with 1 marking an address character.
- R5: A stop bit sampled as 0 sets the framing flag `rx_status[6]`. The receiver then hunts for a new start bit only after the line has returned high.
- R6: A break is a frame whose data, parity and stop bits are all 0. It loads exactly one character of value 0 with `rx_status[7]` set and `rx_status[6]` clear, however long the line stays low.
- R7: The queue holds 3 characters plus one holding register. `rx_status[0]` is 1 while at least one character is stored. `rx_status[1]` is 1 while all 3 queue entries are in use. `rx_status[3:2]` read 0.
- R8: When a character arrives while the queue is full and the holding register is occupied, the holding register is overwritten and the queue is kept. This sets the overrun bit `rx_status[4]`, which stays set until `err_reset` or `rx_reset`.
- R9: With `mode_block` = 0, `rx_status[7:5]` show the flags of the character at the head of the queue (0 when empty). A pop drops that character's flags along with the character.
- R10: With `mode_block` = 1, `rx_status[7:5]` are the OR of the flags of every character received since the last clear, and a pop does not clear them. `err_reset` clears them and the overrun bit, taking priority over a set in the same cycle.
- R11: `rx_reset` empties the queue and the holding register, clears overrun and the accumulated flags, and returns the deserializer to idle.
- R12: A pop while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_tick16 | input | 1 | Enable pulse at 16x the bit rate |
| rx_line | input | 1 | Serial input line, idle high |
| mode_bits | input | 2 | Character length code |
| mode_par | input | 2 | Parity mode code |
| mode_odd | input | 1 | Parity type or forced parity value |
| mode_block | input | 1 | 1 = block error mode, 0 = character error mode |
| pop | input | 1 | Remove the head character |
| err_reset | input | 1 | Clear overrun and accumulated flags |
| rx_reset | input | 1 | Flush the receive path |
| rx_data | output | 8 | Character at the head of the queue |
| rx_status | output | 8 | {break, framing, parity, overrun, 0, 0, full, ready} |

## Verification
The bench targets the fifth arrival into a full queue. A design that drops the new character instead of replacing the held one would return 0x44 where 0x55 is expected, and one that overwrites a queue entry would corrupt an earlier character. It sends a break and holds the line low for several bit times, which catches a receiver that loads repeated zero characters or raises a framing error instead of the break flag. In block mode it pops past a bad character and checks that the parity flag survives; a design that kept the flags only per entry would lose it. It also sends a low glitch shorter than half a bit, which would yield a phantom character in a design that skips the mid-bit check.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int CHAR_MAX = 8;
  localparam int MIN_BITS = 5;

  localparam logic [1:0] PM_WITH  = 2'b00;
  localparam logic [1:0] PM_FORCE = 2'b01;
  localparam logic [1:0] PM_NONE  = 2'b10;
  localparam logic [1:0] PM_MULTI = 2'b11;

  typedef struct packed {
    logic                brk;
    logic                fe;
    logic                pe;
    logic [CHAR_MAX-1:0] data;
  } rx_char_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_WAITHI
  } rx_state_e;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[STAGES-2:0], din};
  end

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] mode_bits,
  input  logic [1:0] mode_par,
  input  logic       mode_odd,
  output logic       char_vld,
  output rx_char_t   char_out
);
  localparam int CNT_W  = $clog2(OVERSAMPLE);
  localparam int MID    = OVERSAMPLE / 2;
  localparam int BIDX_W = $clog2(CHAR_MAX);

  rx_state_e           state;
  logic [CNT_W-1:0]    cnt;
  logic [BIDX_W-1:0]   bit_idx;
  logic [CHAR_MAX-1:0] shreg;
  logic                par_bit;

  logic [BIDX_W-1:0] last_idx;
  logic              par_en, at_mid, at_center, exp_par, pe_calc, is_break;

  assign last_idx  = BIDX_W'(MIN_BITS - 1) + BIDX_W'(mode_bits);
  assign par_en    = (mode_par != PM_NONE);
  assign at_mid    = (cnt == CNT_W'(MID - 1));
  assign at_center = (cnt == CNT_W'(OVERSAMPLE - 1));

  always_comb begin
    exp_par = 1'b0;
    pe_calc = 1'b0;
    case (mode_par)
      PM_WITH: begin
        exp_par = mode_odd ? ~^shreg : ^shreg;
        pe_calc = (par_bit != exp_par);
      end
      PM_FORCE: begin
        exp_par = mode_odd;
        pe_calc = (par_bit != exp_par);
      end
      PM_MULTI: pe_calc = par_bit;
      default:  pe_calc = 1'b0;
    endcase
  end

  assign is_break = !rxd && (shreg == '0) && !(par_en && par_bit);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      par_bit  <= 1'b0;
      char_vld <= 1'b0;
      char_out <= '0;
    end else begin
      char_vld <= 1'b0;
      if (tick) begin
        case (state)
          ST_IDLE: begin
            if (!rxd) begin
              state <= ST_START;
              cnt   <= '0;
            end
          end
          ST_START: begin
            if (rxd) begin
              state <= ST_IDLE;
            end else if (at_mid) begin
              state   <= ST_DATA;
              cnt     <= '0;
              bit_idx <= '0;
              shreg   <= '0;
              par_bit <= 1'b0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          ST_DATA: begin
            if (at_center) begin
              shreg[bit_idx] <= rxd;
              cnt            <= '0;
              if (bit_idx == last_idx) state <= par_en ? ST_PAR : ST_STOP;
              else                     bit_idx <= bit_idx + BIDX_W'(1);
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          ST_PAR: begin
            if (at_center) begin
              par_bit <= rxd;
              cnt     <= '0;
              state   <= ST_STOP;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          ST_STOP: begin
            if (at_center) begin
              cnt      <= '0;
              char_vld <= 1'b1;
              if (rxd) begin
                char_out <= '{brk: 1'b0, fe: 1'b0, pe: pe_calc, data: shreg};
                state    <= ST_IDLE;
              end else if (is_break) begin
                char_out <= '{brk: 1'b1, fe: 1'b0, pe: 1'b0, data: '0};
                state    <= ST_WAITHI;
              end else begin
                char_out <= '{brk: 1'b0, fe: 1'b1, pe: pe_calc, data: shreg};
                state    <= ST_WAITHI;
              end
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          ST_WAITHI: begin
            if (rxd) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 3,
  parameter int W     = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         not_empty,
  output logic         full,
  output logic         ovr_evt
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic [W-1:0]     hold;
  logic             hold_v;

  logic         do_pop, hold_in, mem_we, to_hold, is_full;
  logic [W-1:0] mem_wd;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign is_full = (count == CNT_W'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign hold_in = do_pop && hold_v;
  assign mem_we  = hold_in || (push && (do_pop || !is_full));
  assign mem_wd  = hold_in ? hold : din;
  assign to_hold = push && (hold_in || (!do_pop && is_full));
  assign ovr_evt = push && !do_pop && is_full && hold_v;

  always_ff @(posedge clk) begin
    if (mem_we) mem[wr_ptr] <= mem_wd;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      hold   <= '0;
      hold_v <= 1'b0;
    end else begin
      if (mem_we) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop) rd_ptr <= ptr_inc(rd_ptr);
      case ({mem_we, do_pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
      if (to_hold)      hold <= din;
      if (hold_in)      hold_v <= push;
      else if (to_hold) hold_v <= 1'b1;
    end
  end

  assign dout      = mem[rd_ptr];
  assign not_empty = (count != '0);
  assign full      = is_full;
endmodule

// File: rtl/uart_rx_errfifo.sv
module uart_rx_errfifo
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int FIFO_DEPTH  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_tick16,
  input  logic       rx_line,
  input  logic [1:0] mode_bits,
  input  logic [1:0] mode_par,
  input  logic       mode_odd,
  input  logic       mode_block,
  input  logic       pop,
  input  logic       err_reset,
  input  logic       rx_reset,
  output logic [7:0] rx_data,
  output logic [7:0] rx_status
);
  localparam int ENTRY_W = $bits(rx_char_t);

  logic     rxd_s;
  logic     char_vld;
  rx_char_t char_new, char_top;
  logic     ready, full, ovr_evt;
  logic     overrun;
  logic [2:0] acc_flags, shown_flags;
  logic [ENTRY_W-1:0] top_raw;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rx_line),
    .dout(rxd_s)
  );

  uart_rx_deser #(.OVERSAMPLE(OVERSAMPLE)) u_deser (
    .clk      (clk),
    .rst      (rst),
    .clr      (rx_reset),
    .tick     (rx_tick16),
    .rxd      (rxd_s),
    .mode_bits(mode_bits),
    .mode_par (mode_par),
    .mode_odd (mode_odd),
    .char_vld (char_vld),
    .char_out (char_new)
  );

  uart_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .clr      (rx_reset),
    .push     (char_vld),
    .din      (char_new),
    .pop      (pop),
    .dout     (top_raw),
    .not_empty(ready),
    .full     (full),
    .ovr_evt  (ovr_evt)
  );

  assign char_top = rx_char_t'(top_raw);

  always_ff @(posedge clk) begin
    if (rst || rx_reset || err_reset) begin
      overrun   <= 1'b0;
      acc_flags <= '0;
    end else begin
      if (ovr_evt) overrun <= 1'b1;
      if (char_vld && mode_block)
        acc_flags <= acc_flags | {char_new.brk, char_new.fe, char_new.pe};
    end
  end

  always_comb begin
    if (mode_block)  shown_flags = acc_flags;
    else if (ready)  shown_flags = {char_top.brk, char_top.fe, char_top.pe};
    else             shown_flags = '0;
  end

  assign rx_data   = ready ? char_top.data : '0;
  assign rx_status = {shown_flags, overrun, 2'b00, full, ready};
endmodule

// File: rtl/uart_rx_errfifo_chk.sv
module uart_rx_errfifo_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_reset,
  input logic       err_reset,
  input logic       mode_block,
  input logic [7:0] rx_status
);
  // R7: a full queue always reports a character ready
  p_full_has_ready_r7: assert property (@(posedge clk) disable iff (rst)
    rx_status[1] |-> rx_status[0]);

  // R8: overrun holds until one of the clear commands
  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_status[4] && !err_reset && !rx_reset) |=> rx_status[4]);

  // R10: the clear command wins over any set in the same cycle
  p_errclr_r10: assert property (@(posedge clk) disable iff (rst)
    err_reset |=> (!rx_status[4] && (!mode_block || rx_status[7:5] == 3'b000)));

  // R10: accumulated flags never drop while block mode stays on without a clear
  p_block_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (mode_block && !err_reset && !rx_reset) |=>
      (!mode_block || ((rx_status[7:5] & $past(rx_status[7:5])) == $past(rx_status[7:5]))));

  // R11: receiver reset empties the queue and clears overrun
  p_rxreset_r11: assert property (@(posedge clk) disable iff (rst)
    rx_reset |=> (!rx_status[0] && !rx_status[1] && !rx_status[4]));
endmodule

bind uart_rx_errfifo uart_rx_errfifo_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_reset  (rx_reset),
  .err_reset (err_reset),
  .mode_block(mode_block),
  .rx_status (rx_status)
);

// File: tb/uart_rx_errfifo_tb.sv
module uart_rx_errfifo_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_tick16 = 1'b1;
  logic       rx_line = 1'b1;
  logic [1:0] mode_bits = 2'b11;
  logic [1:0] mode_par = 2'b10;
  logic       mode_odd = 1'b0;
  logic       mode_block = 1'b0;
  logic       pop = 1'b0;
  logic       err_reset = 1'b0;
  logic       rx_reset = 1'b0;
  logic [7:0] rx_data;
  logic [7:0] rx_status;

  int checks = 0;
  int fails = 0;
  int tick_period = 1;
  int tick_cnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (tick_period <= 1) begin
      rx_tick16 <= 1'b1;
    end else if (tick_cnt >= tick_period - 1) begin
      tick_cnt  <= 0;
      rx_tick16 <= 1'b1;
    end else begin
      tick_cnt  <= tick_cnt + 1;
      rx_tick16 <= 1'b0;
    end
  end

  uart_rx_errfifo u_dut (
    .clk       (clk),
    .rst       (rst),
    .rx_tick16 (rx_tick16),
    .rx_line   (rx_line),
    .mode_bits (mode_bits),
    .mode_par  (mode_par),
    .mode_odd  (mode_odd),
    .mode_block(mode_block),
    .pop       (pop),
    .err_reset (err_reset),
    .rx_reset  (rx_reset),
    .rx_data   (rx_data),
    .rx_status (rx_status)
  );

  typedef struct packed {
    logic [1:0] nb;
    logic [1:0] par;
    logic       odd;
    logic [7:0] data;
    logic       flip;
    logic       stop;
    logic [7:0] exp_data;
    logic [2:0] exp_flags;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{2'b11, 2'b10, 1'b0, 8'hA5, 1'b0, 1'b1, 8'hA5, 3'b000},
    '{2'b11, 2'b00, 1'b0, 8'h3C, 1'b0, 1'b1, 8'h3C, 3'b000},
    '{2'b11, 2'b00, 1'b1, 8'h3C, 1'b1, 1'b1, 8'h3C, 3'b001},
    '{2'b00, 2'b10, 1'b0, 8'hFF, 1'b0, 1'b1, 8'h1F, 3'b000},
    '{2'b01, 2'b00, 1'b1, 8'h2A, 1'b0, 1'b1, 8'h2A, 3'b000},
    '{2'b10, 2'b01, 1'b1, 8'h55, 1'b0, 1'b1, 8'h55, 3'b000},
    '{2'b10, 2'b01, 1'b0, 8'h55, 1'b1, 1'b1, 8'h55, 3'b001},
    '{2'b11, 2'b10, 1'b0, 8'h81, 1'b0, 1'b0, 8'h81, 3'b010},
    '{2'b11, 2'b11, 1'b0, 8'h42, 1'b1, 1'b1, 8'h42, 3'b001},
    '{2'b11, 2'b11, 1'b0, 8'h42, 1'b0, 1'b1, 8'h42, 3'b000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic par_of(input logic [1:0] par, input logic odd,
                                  input logic [7:0] d, input logic flip);
    case (par)
      2'b00:   return (odd ? ~^d : ^d) ^ flip;
      2'b01:   return odd ^ flip;
      default: return flip;
    endcase
  endfunction

  task automatic send_frame(input logic [1:0] nb, input logic [1:0] par, input logic odd,
                            input logic [7:0] d, input logic flip, input logic stop,
                            input int low_tail);
    int bc;
    int nbits;
    logic [7:0] dm;
    bc    = 16 * tick_period;
    nbits = int'(nb) + 5;
    dm    = '0;
    for (int i = 0; i < nbits; i++) dm[i] = d[i];
    mode_bits = nb;
    mode_par  = par;
    mode_odd  = odd;
    rx_line = 1'b0;
    repeat (bc) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      rx_line = dm[i];
      repeat (bc) @(negedge clk);
    end
    if (par != 2'b10) begin
      rx_line = par_of(par, odd, dm, flip);
      repeat (bc) @(negedge clk);
    end
    rx_line = stop;
    repeat (bc) @(negedge clk);
    if (!stop) repeat (low_tail) @(negedge clk);
    rx_line = 1'b1;
    repeat (2 * bc) @(negedge clk);
  endtask

  task automatic send8(input logic [7:0] d);
    send_frame(2'b11, 2'b10, 1'b0, d, 1'b0, 1'b1, 0);
  endtask

  task automatic pulse_pop();
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_err();
    err_reset = 1'b1;
    @(negedge clk);
    err_reset = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R7 reset status", rx_status, 32'h00);
    check("R7 reset data", rx_data, 32'h00);

    // Vector table: character length, parity modes, framing, multidrop
    for (int v = 0; v < NVEC; v++) begin
      send_frame(VEC[v].nb, VEC[v].par, VEC[v].odd, VEC[v].data, VEC[v].flip, VEC[v].stop, 0);
      check($sformatf("R2 R3 R4 R5 vec%0d ready", v), rx_status[0], 32'h1);
      check($sformatf("R2 vec%0d data", v), rx_data, VEC[v].exp_data);
      check($sformatf("R3 R4 R5 R9 vec%0d flags", v), rx_status[7:5], VEC[v].exp_flags);
      pulse_pop();
      check($sformatf("R9 vec%0d empty after pop", v), rx_status[0], 32'h0);
    end

    // R1: a short low glitch yields nothing
    rx_line = 1'b0;
    repeat (4) @(negedge clk);
    rx_line = 1'b1;
    repeat (64) @(negedge clk);
    check("R1 glitch ignored", rx_status[0], 32'h0);

    // R1: slower tick enable stretches the bit time
    tick_period = 2;
    repeat (4) @(negedge clk);
    send8(8'h5A);
    check("R1 tick gated data", rx_data, 32'h5A);
    pulse_pop();
    tick_period = 1;
    repeat (4) @(negedge clk);

    // R6: break held low for several bit times
    send_frame(2'b11, 2'b10, 1'b0, 8'h00, 1'b0, 1'b0, 48);
    check("R6 break data", rx_data, 32'h00);
    check("R6 break flags", rx_status[7:5], 32'h4);
    pulse_pop();
    check("R6 single break char", rx_status[0], 32'h0);

    // R9: flags follow each character
    send_frame(2'b11, 2'b00, 1'b0, 8'h11, 1'b1, 1'b1, 0);
    send_frame(2'b11, 2'b00, 1'b0, 8'h22, 1'b0, 1'b1, 0);
    check("R9 head flags bad char", rx_status[7:5], 32'h1);
    pulse_pop();
    check("R9 flags drop with pop", rx_status[7:5], 32'h0);
    check("R9 next data", rx_data, 32'h22);
    pulse_pop();

    // R10: block mode accumulates across pops
    mode_block = 1'b1;
    pulse_err();
    send_frame(2'b11, 2'b00, 1'b0, 8'h11, 1'b1, 1'b1, 0);
    send_frame(2'b11, 2'b00, 1'b0, 8'h22, 1'b0, 1'b1, 0);
    check("R10 accumulated", rx_status[7:5], 32'h1);
    pulse_pop();
    check("R10 kept after pop", rx_status[7:5], 32'h1);
    pulse_pop();
    check("R10 kept when empty", rx_status[7:0], 32'h20);
    pulse_err();
    check("R10 err_reset clears", rx_status[7:5], 32'h0);
    mode_block = 1'b0;

    // R7 / R8: fill, hold, overrun
    send8(8'h11);
    send8(8'h22);
    check("R7 not full at two", rx_status[1], 32'h0);
    send8(8'h33);
    check("R7 full at three", rx_status[1:0], 32'h3);
    send8(8'h44);
    check("R8 no overrun with hold free", rx_status[4], 32'h0);
    send8(8'h55);
    check("R8 overrun set", rx_status[4], 32'h1);
    check("R8 head preserved", rx_data, 32'h11);
    pulse_pop();
    check("R8 second", rx_data, 32'h22);
    check("R7 full after hold moves in", rx_status[1], 32'h1);
    pulse_pop();
    check("R8 third", rx_data, 32'h33);
    pulse_pop();
    check("R8 held char replaced", rx_data, 32'h55);
    pulse_pop();
    check("R8 drained", rx_status[0], 32'h0);
    check("R8 overrun sticky", rx_status[4], 32'h1);
    pulse_err();
    check("R8 err_reset clears overrun", rx_status[4], 32'h0);

    // R12: pop on empty
    pulse_pop();
    check("R12 empty pop status", rx_status, 32'h00);
    send8(8'h66);
    check("R12 next char intact", rx_data, 32'h66);
    pulse_pop();
    check("R12 empty again", rx_status[0], 32'h0);

    // R11: receiver reset flushes everything
    mode_block = 1'b1;
    send_frame(2'b11, 2'b10, 1'b0, 8'h77, 1'b0, 1'b0, 0);
    send8(8'h78);
    rx_reset = 1'b1;
    @(negedge clk);
    rx_reset = 1'b0;
    @(negedge clk);
    check("R11 status cleared", rx_status, 32'h00);
    mode_block = 1'b0;
    send8(8'h12);
    check("R11 receiver usable", rx_data, 32'h12);
    pulse_pop();

    summary();
  end

endmodule